// File: doc/BRIEF.md
# Quadrature limiter FSK demodulator

This block recovers binary NRZ frequency-shift-keyed data from the two hard-limited baseband signals of a zero-IF receiver. The in-phase and quadrature channels each arrive as a single asynchronous bit. The block resynchronises both and finds their rising and falling edges. From the order in which the edges occur, it works out whether the signal phasor turns clockwise or counter-clockwise. Clockwise means the carrier is below the local oscillator, which is a mark (1). Counter-clockwise means it is above, which is a space (0).

Three decisions are offered side by side, and the downstream slicer chooses among them:
- a single-flop decision that updates only on rising in-phase edges;
- a symmetric two-flop sum with a half-height middle level, so a noise edge on one channel costs only half a step;
- a quadrant-tracking decision that updates on every edge of either channel, which gives the shortest delay after a frequency reversal.

A sample-enable input lets a slow sampling tick drive the whole pipeline from a faster system clock. The inputs are raw limiter levels and the results are plain levels, so no pin carries a handshake and there is no back-pressure.

Top module: `quad_edge_fsk_demod`

## Requirements
- R1: A level change on `i_lim` or `q_lim` first affects the decisions at the third enabled clock edge after it is applied: two synchroniser stages, then one decision register.
- R2: On each rising edge of the synchronised in-phase channel, `dec_simple` takes the synchronised quadrature level and holds it until the next such edge. A clockwise tone therefore gives a constant 1. The phasor quadrants are coded 0=(I1,Q1), 1=(I0,Q1), 2=(I0,Q0), 3=(I1,Q0), with counter-clockwise steps increasing the code.
- R3: A counter-clockwise tone (space) gives a constant 0 on every decision once each has seen its first edge.
- R4: A second flop takes the inverted in-phase level on each rising quadrature edge. `dec_sum` is the sum of the two flops, so it is 0, 1 or 2, never 3. A single spurious quadrature pulse during a mark drops the sum to 1 and not to 0.
- R5: `dec_track` follows every single-channel edge. A clockwise quadrant step sets it to 1 and a counter-clockwise step sets it to 0.
- R6: If both channels change in the same enabled sample, `jump_err` pulses high for one clock and `dec_track` keeps its value.
- R7: A steady tone that never crosses the local oscillator frequency produces no output transitions, whatever its rate.
- R8: While `samp_en` is low, nothing advances: all decisions hold and `jump_err` stays 0.
- R9: The synchronous active-high `rst` clears all decisions and `jump_err`, and loads every pipeline stage from the current inputs. A reset held for at least three clocks on steady inputs therefore causes no edge after release.
- R10: After a reversal from mark to space, `dec_track` settles within one quarter period plus the pipeline delay. `dec_simple` settles within four quarter periods plus the pipeline delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Sampling tick; the pipeline advances only when high |
| i_lim | input | 1 | In-phase limiter output, asynchronous |
| q_lim | input | 1 | Quadrature limiter output, asynchronous |
| dec_simple | output | 1 | Single-flop decision, rising in-phase edges only |
| dec_sum | output | 2 | Sum of the two cross-clocked flops (0..2) |
| dec_track | output | 1 | Quadrant-tracking decision, every edge |
| jump_err | output | 1 | One-clock pulse on a two-quadrant jump |

## Verification
An input level reaches the decision registers on the third enabled edge after it is driven: two synchroniser stages, then the decision register. `jump_err` rises at that same edge and falls one clock later. The bench model keeps the last three enabled samples in a queue and compares all four outputs on every falling clock edge. It recomputes the expected decision from the oldest pair of samples in that queue, so the latency is built into every comparison. Separate checks sample `dec_track` exactly two and three clocks after a single step. They also bound the settling time after a reversal by one quarter period (tracking decision) and four quarter periods (simple decision), each plus the pipeline delay.

// File: rtl/qfsk_pkg.sv
package qfsk_pkg;
  // channel positions inside the two-bit sample word
  localparam int unsigned CH_I = 1;
  localparam int unsigned CH_Q = 0;

  typedef logic [1:0] quad_t;

  // rotation step between two successive quadrant codes
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_CCW  = 2'd1,
    STEP_JUMP = 2'd2,
    STEP_CW   = 2'd3
  } step_e;

  // quadrant code of a limiter pair; counter-clockwise increases the code
  function automatic quad_t quad_of(input logic i_bit, input logic q_bit);
    case ({i_bit, q_bit})
      2'b11:   return 2'd0;
      2'b01:   return 2'd1;
      2'b00:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/qfsk_sync.sv
module qfsk_sync #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0][WIDTH-1:0] chain;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst || en) chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst || en) chain <= {chain[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[LAST];
endmodule

// File: rtl/qfsk_edge.sv
module qfsk_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  always_ff @(posedge clk) begin
    if (rst || en) prev <= cur;
  end

  generate
    for (genvar c = 0; c < WIDTH; c++) begin : g_chan
      assign rise[c] = en &  cur[c] & ~prev[c];
      assign fall[c] = en & ~cur[c] &  prev[c];
    end
  endgenerate
endmodule

// File: rtl/qfsk_decide.sv
module qfsk_decide
  import qfsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] cur,
  input  logic [1:0] prev,
  input  logic [1:0] rise,
  input  logic [1:0] fall,
  output logic       dec_simple,
  output logic [1:0] dec_sum,
  output logic       dec_track,
  output logic       jump_err
);
  logic       ff_i_clk;  // samples Q on rising I
  logic       ff_q_clk;  // samples inverted I on rising Q
  logic [1:0] moved;
  step_e      step;

  assign moved = rise | fall;
  assign step  = step_e'(quad_of(cur[CH_I], cur[CH_Q]) - quad_of(prev[CH_I], prev[CH_Q]));

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_i_clk <= 1'b0;
      ff_q_clk <= 1'b0;
    end else begin
      if (rise[CH_I]) ff_i_clk <= cur[CH_Q];
      if (rise[CH_Q]) ff_q_clk <= ~cur[CH_I];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_track <= 1'b0;
      jump_err  <= 1'b0;
    end else begin
      jump_err <= 1'b0;
      if (en) begin
        if (moved == 2'b11) begin
          jump_err <= 1'b1;
        end else if (moved != 2'b00) begin
          dec_track <= (step == STEP_CW);
        end
      end
    end
  end

  assign dec_simple = ff_i_clk;
  assign dec_sum    = {1'b0, ff_i_clk} + {1'b0, ff_q_clk};
endmodule

// File: rtl/quad_edge_fsk_demod.sv
module quad_edge_fsk_demod
  import qfsk_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       samp_en,
  input  logic       i_lim,
  input  logic       q_lim,
  output logic       dec_simple,
  output logic [1:0] dec_sum,
  output logic       dec_track,
  output logic       jump_err
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw;
  logic [NCH-1:0] cur;
  logic [NCH-1:0] prev;
  logic [NCH-1:0] rise;
  logic [NCH-1:0] fall;

  assign raw[CH_I] = i_lim;
  assign raw[CH_Q] = q_lim;

  qfsk_sync #(.DEPTH(SYNC_DEPTH), .WIDTH(NCH)) u_sync (
    .clk (clk),
    .rst (rst),
    .en  (samp_en),
    .din (raw),
    .dout(cur)
  );

  qfsk_edge #(.WIDTH(NCH)) u_edge (
    .clk (clk),
    .rst (rst),
    .en  (samp_en),
    .cur (cur),
    .prev(prev),
    .rise(rise),
    .fall(fall)
  );

  qfsk_decide u_decide (
    .clk       (clk),
    .rst       (rst),
    .en        (samp_en),
    .cur       (cur),
    .prev      (prev),
    .rise      (rise),
    .fall      (fall),
    .dec_simple(dec_simple),
    .dec_sum   (dec_sum),
    .dec_track (dec_track),
    .jump_err  (jump_err)
  );
endmodule

// File: rtl/qfsk_checker.sv
module qfsk_checker (
  input logic       clk,
  input logic       rst,
  input logic       samp_en,
  input logic       dec_simple,
  input logic [1:0] dec_sum,
  input logic       dec_track,
  input logic       jump_err
);
  assert_sum_range_R4: assert property (@(posedge clk) disable iff (rst)
    dec_sum != 2'd3);

  assert_sum_top_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_sum == 2'd2) |-> dec_simple);

  assert_jump_hold_R6: assert property (@(posedge clk) disable iff (rst)
    jump_err |-> $stable(dec_track));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(samp_en) |-> ($stable(dec_simple) && $stable(dec_sum)
                         && $stable(dec_track) && !jump_err));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!dec_simple && dec_sum == 2'd0 && !dec_track && !jump_err));
endmodule

bind quad_edge_fsk_demod qfsk_checker u_qfsk_checker (
  .clk       (clk),
  .rst       (rst),
  .samp_en   (samp_en),
  .dec_simple(dec_simple),
  .dec_sum   (dec_sum),
  .dec_track (dec_track),
  .jump_err  (jump_err)
);

// File: tb/quad_edge_fsk_demod_bench.sv
module quad_edge_fsk_demod_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4;          // clocks per quadrant step
  localparam int PIPE = 3;         // stated input-to-decision latency

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       samp_en = 1'b1;
  logic       i_lim = 1'b1;
  logic       q_lim = 1'b1;
  logic       dec_simple;
  logic [1:0] dec_sum;
  logic       dec_track;
  logic       jump_err;

  int n_checks = 0;
  int n_errors = 0;
  int cur_ph = 0;
  int en_mode = 0;                 // 0 always, 1 every other clock, 2 off

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_edge_fsk_demod u_quad_edge_fsk_demod (
    .clk(clk), .rst(rst), .samp_en(samp_en), .i_lim(i_lim), .q_lim(q_lim),
    .dec_simple(dec_simple), .dec_sum(dec_sum), .dec_track(dec_track),
    .jump_err(jump_err)
  );

  always @(negedge clk) begin
    if (en_mode == 0) samp_en = 1'b1;
    else if (en_mode == 1) samp_en = ~samp_en;
    else samp_en = 1'b0;
  end

  // ---------------- behavioural reference ----------------
  int hist_i[$];
  int hist_q[$];
  int m_a = 0, m_b = 0, m_track = 0, m_err = 0;

  function automatic int angle(int iv, int qv);
    if (iv == 1 && qv == 1) return 0;
    if (iv == 0 && qv == 1) return 1;
    if (iv == 0 && qv == 0) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist_i = {}; hist_q = {};
      for (int k = 0; k < PIPE; k++) begin
        hist_i.push_back(int'(i_lim)); hist_q.push_back(int'(q_lim));
      end
      m_a = 0; m_b = 0; m_track = 0; m_err = 0;
    end else begin
      m_err = 0;
      if (samp_en) begin
        int oi, oq, ni, nq, d;
        oi = hist_i[0]; oq = hist_q[0]; ni = hist_i[1]; nq = hist_q[1];
        d = (angle(ni, nq) - angle(oi, oq) + 4) % 4;
        if (oi == 0 && ni == 1) m_a = nq;
        if (oq == 0 && nq == 1) m_b = 1 - ni;
        if (d == 2) m_err = 1;
        else if (d == 1) m_track = 0;
        else if (d == 3) m_track = 1;
        hist_i.push_back(int'(i_lim)); hist_q.push_back(int'(q_lim));
        void'(hist_i.pop_front()); void'(hist_q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    n_checks++;
    if (int'(dec_simple) != m_a) begin
      n_errors++; $display("FAIL R2 dec_simple act=%0d exp=%0d", dec_simple, m_a);
    end
    if (int'(dec_sum) != m_a + m_b) begin
      n_errors++; $display("FAIL R4 dec_sum act=%0d exp=%0d", dec_sum, m_a + m_b);
    end
    if (int'(dec_track) != m_track) begin
      n_errors++; $display("FAIL R5 dec_track act=%0d exp=%0d", dec_track, m_track);
    end
    if (int'(jump_err) != m_err) begin
      n_errors++; $display("FAIL R6 jump_err act=%0d exp=%0d", jump_err, m_err);
    end
  end

  // ---------------- observation helpers ----------------
  bit cnt_on = 0;
  int toggles = 0;
  logic l_s, l_t;
  logic [1:0] l_sum;
  bit saw_half = 0, saw_err = 0;

  always @(negedge clk) begin
    if (cnt_on && (dec_simple !== l_s || dec_sum !== l_sum || dec_track !== l_t))
      toggles++;
    l_s = dec_simple; l_sum = dec_sum; l_t = dec_track;
    if (dec_sum == 2'd1) saw_half = 1;
    if (jump_err) saw_err = 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int ph);
    cur_ph = ph;
    case (ph)
      0: begin i_lim = 1; q_lim = 1; end
      1: begin i_lim = 0; q_lim = 1; end
      2: begin i_lim = 0; q_lim = 0; end
      default: begin i_lim = 1; q_lim = 0; end
    endcase
  endtask

  task automatic rotate(input int dir, input int n, input int len);
    for (int k = 0; k < n; k++) begin
      put((cur_ph + dir + 4) % 4);
      repeat (len) @(negedge clk);
    end
  endtask

  task automatic steady_window(input int dir, input int exp_s, input int exp_sum,
                               input int exp_t, input string req);
    cnt_on = 1; toggles = 0;
    rotate(dir, 16, QTR);
    cnt_on = 0;
    chk(toggles == 0, "R7", "toggles on steady tone", toggles, 0);
    chk(int'(dec_simple) == exp_s, req, "dec_simple steady", dec_simple, exp_s);
    chk(int'(dec_sum) == exp_sum, "R4", "dec_sum steady", dec_sum, exp_sum);
    chk(int'(dec_track) == exp_t, "R5", "dec_track steady", dec_track, exp_t);
  endtask

  task automatic wait_track(input int exp, input int limit);
    int n = 0;
    while (int'(dec_track) != exp && n <= limit) begin @(negedge clk); n++; end
    chk(n <= limit, "R10", "dec_track settle clocks", n, limit);
  endtask

  task automatic wait_simple(input int exp, input int limit);
    int n = 0;
    while (int'(dec_simple) != exp && n <= limit) begin @(negedge clk); n++; end
    chk(n <= limit, "R10", "dec_simple settle clocks", n, limit);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    put(0);
    repeat (6) @(negedge clk);
    chk(dec_simple == 0 && dec_sum == 0 && dec_track == 0 && jump_err == 0,
        "R9", "outputs in reset", int'(dec_track), 0);
    rst = 0;
    repeat (4) @(negedge clk);

    // R1: single clockwise step reaches dec_track on the third edge
    put(3);
    repeat (2) @(negedge clk);
    chk(dec_track == 0, "R1", "dec_track two clocks after step", dec_track, 0);
    @(negedge clk);
    chk(dec_track == 1, "R1", "dec_track three clocks after step", dec_track, 1);
    repeat (QTR) @(negedge clk);

    // mark tone (clockwise), steady values
    rotate(-1, 12, QTR);
    steady_window(-1, 1, 2, 1, "R2");

    // reversal to space, settle bounds
    fork
      rotate(1, 12, QTR);
      wait_track(0, QTR + PIPE + 1);
      wait_simple(0, 4 * QTR + PIPE + 1);
    join
    steady_window(1, 0, 0, 0, "R3");

    // single spurious Q pulse during a mark gives a half step only
    rotate(-1, 12, QTR);
    while (cur_ph != 0) rotate(-1, 1, QTR);
    saw_half = 0;
    q_lim = 0;
    repeat (2) @(negedge clk);
    q_lim = 1;
    repeat (6) @(negedge clk);
    chk(saw_half, "R4", "half-height sum after one-channel glitch", saw_half, 1);
    chk(dec_simple == 1, "R4", "dec_simple unaffected by Q glitch", dec_simple, 1);
    rotate(-1, 8, QTR);

    // two-quadrant jump
    begin
      logic t_before;
      repeat (2) @(negedge clk);
      t_before = dec_track;
      saw_err = 0;
      put((cur_ph + 2) % 4);
      repeat (6) @(negedge clk);
      chk(saw_err, "R6", "jump_err pulse on double change", saw_err, 1);
      chk(dec_track == t_before, "R6", "dec_track held over jump", dec_track, t_before);
    end

    // half-rate sampling
    en_mode = 1;
    rotate(1, 20, 6);
    chk(dec_track == 0, "R5", "dec_track at half-rate space", dec_track, 0);

    // sampling stopped
    en_mode = 2;
    repeat (3) @(negedge clk);
    begin
      logic s0, t0;
      logic [1:0] m0;
      s0 = dec_simple; t0 = dec_track; m0 = dec_sum;
      saw_err = 0;
      rotate(-1, 10, 2);
      put((cur_ph + 2) % 4);
      repeat (3) @(negedge clk);
      chk(dec_simple == s0 && dec_sum == m0 && dec_track == t0, "R8",
          "outputs held with samp_en low", int'(dec_track), int'(t0));
      chk(!saw_err, "R8", "no jump_err with samp_en low", saw_err, 0);
    end
    en_mode = 0;
    rotate(-1, 12, QTR);

    // mid-run reset on a steady non-zero input
    rst = 1;
    repeat (5) @(negedge clk);
    chk(dec_simple == 0 && dec_sum == 0 && dec_track == 0, "R9",
        "outputs cleared by reset", int'(dec_sum), 0);
    rst = 0;
    saw_err = 0;
    cnt_on = 1; toggles = 0;
    repeat (10) @(negedge clk);
    cnt_on = 0;
    chk(toggles == 0 && !saw_err, "R9", "no edge after reset release", toggles, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule